// File: doc/BRIEF.md
# Out-of-Order Load/Store Data Order Tracker

This block keeps a list of load and store instructions that have completed and sent their address, but whose data has not yet been put on the trace. The data of such an instruction may be held back, for example by a cache miss on a load or a store operand that is not ready yet. Meanwhile other instructions keep completing, and each deferred value is traced as soon as it arrives. The list is kept in program order. Each completing load or store is added at the young end through an allocate strobe that carries an instruction tag.

When a data-ready strobe arrives with a tag, the block finds that tag in the list. On the next cycle it reports a 4-bit order index, which is the age rank of the entry among the outstanding ones, with 0 for the oldest. It then removes the entry, and every younger entry moves up one rank. A trace unit downstream sends the index alongside the data value, so that software can match the value to the right instruction. The list holds at most sixteen entries. When it is full the block raises a full flag and drops allocations, and the requester must stall.

Top module: `order_tracker`

## Requirements
- R1: After reset the list is empty: `full`, `orderValid` and `tagError` are low, and a data-ready strobe for any tag is reported as a tag error.
- R2: A data-ready strobe for the tag of the oldest outstanding entry makes `orderValid` high with `orderIdx` = 0 in the cycle after the strobe (the in-order case).
- R3: A data-ready strobe for the tag of the (n+1)-th oldest outstanding entry gives `orderIdx` = n, with `orderValid` high, in the cycle after the strobe.
- R4: Retiring an entry removes it from the list, and every entry younger than it drops one rank. Older entries keep their ranks.
- R5: The list holds at most 16 entries. `full` is high from the cycle after the 16th entry is accepted, and goes low in the cycle after a retirement frees a slot.
- R6: An allocate strobe while `full` is high is dropped. A later data-ready strobe for that dropped tag reports a tag error, and the ranks of the stored entries do not change.
- R7: When an allocation and a data-ready strobe fall in the same cycle, the rank is found on the list as it was before the new entry is added. The new entry cannot match that strobe, and it becomes the youngest entry after the retirement.
- R8: A data-ready strobe whose tag is not outstanding gives a one-cycle `tagError` pulse with `orderValid` low, and leaves the list unchanged.
- R9: If the same tag is outstanding more than once, a data-ready strobe for it matches and retires the oldest copy.
- R10: `orderValid` and `tagError` are single-cycle responses to a data-ready strobe, they are never high together, and both are low in a cycle that follows no data-ready strobe. `orderIdx` reads 0 whenever `orderValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| allocValid | input | 1 | A load/store completed and needs a data slot |
| allocTag | input | 6 | Tag of the completing load/store |
| dataValid | input | 1 | Data of an outstanding load/store is available |
| dataTag | input | 6 | Tag of the instruction whose data is available |
| orderIdx | output | 4 | Age rank of the retired entry (0 = oldest) |
| orderValid | output | 1 | `orderIdx` is valid this cycle |
| tagError | output | 1 | The last data-ready tag was not outstanding |
| full | output | 1 | Sixteen entries are outstanding; allocation is dropped |

## Verification
The assertions take for granted that the inputs are clean binary values on each clock edge, and they make no assumption about how tags repeat or how well the requester respects `full`. Because of that, the stimulus is free to allocate while full, reuse tags, and send data-ready strobes for tags that are missing, in the same cycle as an allocation or on their own. The random phase mostly chooses data-ready tags from the bench's own copy of the list, so that most strobes hit and ranks across the whole depth are exercised. About one strobe in eight uses an arbitrary tag, so error responses and duplicate matches also occur.

// File: rtl/order_tracker_pkg.sv
package order_tracker_pkg;
  // Number of outstanding load/store data values the list can hold.
  parameter int TRK_DEPTH = 16;
  // Width of the instruction tag carried by allocate and data-ready strobes.
  parameter int TRK_TAG_W = 6;

  localparam int ORD_W = $clog2(TRK_DEPTH);
  localparam int CNT_W = $clog2(TRK_DEPTH + 1);

  // Strobes from control to the entry datapath.
  typedef struct packed {
    logic             retire;     // remove entry at retireIdx and compact
    logic [ORD_W-1:0] retireIdx;  // rank of the entry leaving the list
    logic             push;       // write allocTag at pushIdx
    logic [CNT_W-1:0] pushIdx;    // slot after compaction
  } trkStrobes_t;
endpackage

// File: rtl/order_tracker_dp.sv
module order_tracker_dp
  import order_tracker_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  trkStrobes_t          strobes,
  input  logic [TRK_TAG_W-1:0] allocTag,
  input  logic [TRK_TAG_W-1:0] dataTag,
  output logic [TRK_DEPTH-1:0] matchVec,
  output logic [TRK_DEPTH-1:0] validVec
);
  // Entry 0 is the oldest outstanding load/store.
  logic [TRK_TAG_W-1:0] tagQ   [TRK_DEPTH];
  logic [TRK_TAG_W-1:0] tagNext[TRK_DEPTH];
  logic [TRK_DEPTH-1:0] vldQ;
  logic [TRK_DEPTH-1:0] vldNext;

  assign validVec = vldQ;

  for (genvar j = 0; j < TRK_DEPTH; j++) begin : gEntry
    logic                 shiftIn;
    logic [TRK_TAG_W-1:0] shTag;
    logic                 shVld;

    assign matchVec[j] = vldQ[j] && (tagQ[j] == dataTag);
    assign shiftIn     = strobes.retire && (ORD_W'(j) >= strobes.retireIdx);

    if (j < TRK_DEPTH - 1) begin : gMid
      assign shTag = shiftIn ? tagQ[j+1] : tagQ[j];
      assign shVld = shiftIn ? vldQ[j+1] : vldQ[j];
    end else begin : gLast
      assign shTag = shiftIn ? '0 : tagQ[j];
      assign shVld = shiftIn ? 1'b0 : vldQ[j];
    end

    always_comb begin
      tagNext[j] = shTag;
      vldNext[j] = shVld;
      if (strobes.push && (CNT_W'(j) == strobes.pushIdx)) begin
        tagNext[j] = allocTag;
        vldNext[j] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[j] <= '0;
        vldQ[j] <= 1'b0;
      end else begin
        tagQ[j] <= tagNext[j];
        vldQ[j] <= vldNext[j];
      end
    end
  end

  // Occupied slots always form a block at the old end of the list.
  logic [TRK_DEPTH:0] fillPlusOne;
  assign fillPlusOne = {1'b0, vldQ} + 1'b1;

  assert_packed_list_R4 : assert property (@(posedge clk) disable iff (!rstN)
    ((fillPlusOne[TRK_DEPTH-1:0] & vldQ) == '0));

  // A push never lands on an occupied slot that stays occupied.
  assert_push_free_slot_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && !strobes.retire) |-> !vldQ[strobes.pushIdx[ORD_W-1:0]]);
endmodule

// File: rtl/order_tracker_ctl.sv
module order_tracker_ctl
  import order_tracker_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic                 dataValid,
  input  logic [TRK_DEPTH-1:0] matchVec,
  output trkStrobes_t          strobes,
  output logic [CNT_W-1:0]     entryCount,
  output logic [ORD_W-1:0]     orderIdx,
  output logic                 orderValid,
  output logic                 tagError,
  output logic                 full
);
  logic [CNT_W-1:0] countQ;
  logic             anyMatch;
  logic             hit;
  logic             miss;
  logic             accept;
  logic [ORD_W-1:0] hitIdx;

  assign entryCount = countQ;
  assign full       = (countQ == CNT_W'(TRK_DEPTH));
  assign anyMatch   = |matchVec;
  assign hit        = dataValid && anyMatch;
  assign miss       = dataValid && !anyMatch;
  assign accept     = allocValid && !full;

  // Oldest matching entry wins when a tag is outstanding twice.
  always_comb begin
    hitIdx = '0;
    for (int i = TRK_DEPTH - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = ORD_W'(i);
    end
  end

  always_comb begin
    strobes.retire    = hit;
    strobes.retireIdx = hitIdx;
    strobes.push      = accept;
    strobes.pushIdx   = countQ - CNT_W'(hit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ     <= '0;
      orderIdx   <= '0;
      orderValid <= 1'b0;
      tagError   <= 1'b0;
    end else begin
      countQ     <= countQ + CNT_W'(accept) - CNT_W'(hit);
      orderValid <= hit;
      orderIdx   <= hit ? hitIdx : '0;
      tagError   <= miss;
    end
  end

  assert_no_overflow_R5 : assert property (@(posedge clk) disable iff (!rstN)
    countQ <= CNT_W'(TRK_DEPTH));

  assert_full_drops_alloc_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (full && allocValid && !hit) |=> full);

  assert_rank_in_range_R3 : assert property (@(posedge clk) disable iff (!rstN)
    hit |=> (orderValid && (CNT_W'(orderIdx) < $past(countQ))));

  assert_miss_flags_error_R8 : assert property (@(posedge clk) disable iff (!rstN)
    miss |=> (tagError && !orderValid));

  assert_exclusive_resp_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !(orderValid && tagError));

  assert_idle_quiet_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |=> (!orderValid && !tagError));
endmodule

// File: rtl/order_tracker.sv
module order_tracker
  import order_tracker_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic [TRK_TAG_W-1:0] allocTag,
  input  logic                 dataValid,
  input  logic [TRK_TAG_W-1:0] dataTag,
  output logic [ORD_W-1:0]     orderIdx,
  output logic                 orderValid,
  output logic                 tagError,
  output logic                 full
);
  trkStrobes_t          strobes;
  logic [TRK_DEPTH-1:0] matchVec;
  logic [TRK_DEPTH-1:0] validVec;
  logic [CNT_W-1:0]     entryCount;

  order_tracker_ctl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .allocValid (allocValid),
    .dataValid  (dataValid),
    .matchVec   (matchVec),
    .strobes    (strobes),
    .entryCount (entryCount),
    .orderIdx   (orderIdx),
    .orderValid (orderValid),
    .tagError   (tagError),
    .full       (full)
  );

  order_tracker_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .allocTag (allocTag),
    .dataTag  (dataTag),
    .matchVec (matchVec),
    .validVec (validVec)
  );

  // Occupancy counted by control agrees with slots held in the datapath.
  assert_count_agrees_R5 : assert property (@(posedge clk) disable iff (!rstN)
    $countones(validVec) == int'(entryCount));
endmodule

// File: tb/tb_order_tracker.sv
module tb_order_tracker;
  import order_tracker_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MAXQ       = TRK_DEPTH;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 allocValid = 1'b0;
  logic [TRK_TAG_W-1:0] allocTag = '0;
  logic                 dataValid = 1'b0;
  logic [TRK_TAG_W-1:0] dataTag = '0;
  logic [ORD_W-1:0]     orderIdx;
  logic                 orderValid;
  logic                 tagError;
  logic                 full;

  int checks = 0;
  int errors = 0;
  int mq[MAXQ];
  int mc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  order_tracker dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocTag(allocTag),
    .dataValid(dataValid), .dataTag(dataTag), .orderIdx(orderIdx),
    .orderValid(orderValid), .tagError(tagError), .full(full)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model: find rank of oldest copy of a tag, -1 when absent.
  function automatic int findRank(int tag);
    for (int i = 0; i < mc; i++) if (mq[i] == tag) return i;
    return -1;
  endfunction

  // One cycle: drive, update model, check registered outputs after the edge.
  task automatic step(string req, bit aV, int aT, bit dV, int dT);
    int  rank;
    bit  wasFull;
    bit  expValid;
    bit  expErr;
    int  expIdx;
    @(negedge clk);
    allocValid = aV; allocTag = TRK_TAG_W'(aT);
    dataValid  = dV; dataTag  = TRK_TAG_W'(dT);
    rank     = dV ? findRank(dT) : -1;
    wasFull  = (mc == MAXQ);
    expValid = dV && (rank >= 0);
    expErr   = dV && (rank < 0);
    expIdx   = expValid ? rank : 0;
    if (expValid) begin
      for (int i = rank; i < mc - 1; i++) mq[i] = mq[i+1];
      mc--;
    end
    if (aV && !wasFull) begin
      mq[mc] = aT;
      mc++;
    end
    @(posedge clk);
    #1;
    check(req, "orderValid", int'(orderValid), int'(expValid));
    check(req, "orderIdx", int'(orderIdx), expIdx);
    check(req, "tagError", int'(tagError), int'(expErr));
    check(req, "full", int'(full), int'(mc == MAXQ));
  endtask

  task automatic drain(string req);
    while (mc > 0) step(req, 1'b0, 0, 1'b1, mq[0]);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "full", int'(full), 0);
    check("R1", "orderValid", int'(orderValid), 0);
    check("R1", "tagError", int'(tagError), 0);
    @(negedge clk); rstN = 1'b1;
    step("R1", 1'b0, 0, 1'b1, 9);            // empty list: error

    // R2, R3, R4: ranks and compaction
    for (int t = 10; t < 14; t++) step("R3", 1'b1, t, 1'b0, 0);
    step("R2", 1'b0, 0, 1'b1, 10);           // oldest -> 0
    step("R3", 1'b0, 0, 1'b1, 12);           // 11,12,13 -> 1
    step("R4", 1'b0, 0, 1'b1, 13);           // moved up to 1
    step("R4", 1'b0, 0, 1'b1, 11);           // now 0
    step("R10", 1'b0, 0, 1'b0, 0);           // idle: quiet

    // R5, R6: fill, drop while full
    for (int t = 20; t < 36; t++) step("R5", 1'b1, t, 1'b0, 0);
    step("R6", 1'b1, 50, 1'b0, 0);           // dropped
    step("R6", 1'b0, 0, 1'b1, 35);           // youngest -> 15
    step("R6", 1'b0, 0, 1'b1, 50);           // dropped tag: error
    step("R6", 1'b0, 0, 1'b1, 27);           // unchanged ranks -> 7
    drain("R4");

    // R7: same-cycle allocate and data-ready
    step("R7", 1'b1, 40, 1'b0, 0);
    step("R7", 1'b1, 41, 1'b1, 41);          // new entry cannot match
    step("R7", 1'b1, 42, 1'b1, 40);          // rank 0, 42 joins
    step("R7", 1'b0, 0, 1'b1, 42);           // 41,42 -> 1
    // R8: unknown tag leaves state
    step("R8", 1'b0, 0, 1'b1, 63);
    step("R8", 1'b0, 0, 1'b1, 41);           // still 0
    // R9: duplicates resolve oldest first
    step("R9", 1'b1, 5, 1'b0, 0);
    step("R9", 1'b1, 7, 1'b0, 0);
    step("R9", 1'b1, 5, 1'b0, 0);
    step("R9", 1'b0, 0, 1'b1, 5);            // -> 0
    step("R9", 1'b0, 0, 1'b1, 5);            // 7,5 -> 1
    drain("R4");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      bit aV;
      bit dV;
      int dT;
      aV = ($urandom % 100) < 55;
      dV = ($urandom % 100) < 50;
      if (mc > 0 && ($urandom % 8) != 0) dT = mq[$urandom % mc];
      else dT = int'($urandom % (1 << TRK_TAG_W));
      step(dV ? "R3" : "R10", aV, int'($urandom % (1 << TRK_TAG_W)), dV, dT);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule